// File: doc/BRIEF.md
# Sized Shift and Rotate Unit with Extend Flag

This block performs the shift and rotate group of a processor data path on byte, word or long operands. It has eight operations: arithmetic and logical shifts in each direction, plain rotates in each direction, and rotates that pass through the extend flag as one extra bit position. The operand comes from a destination register. Only the low byte or word of that register changes for the narrower sizes, and the bits above the selected size pass through unchanged.

The count comes from one of two places. One source is a 3-bit field in the instruction, where zero stands for eight. The other source is the low six bits of a count register. A memory-operand mode forces a word-sized shift by exactly one, whatever the size and count inputs hold. The unit returns the new register value, the carry, overflow, negative and zero flags, the new extend flag, and a strobe that tells the flag file whether extend is to be written. All results are registered, so they appear one clock after the inputs.

Top module: `shiftrot_unit`

## Requirements
- R1: `size_sel` selects the operand size: 00 is byte, 01 is word, 10 and 11 are long. Result bits above the selected size equal the matching bits of `dst_in`.
- R2: With `cnt_src`=0 the count is `cnt_imm` read as 1 to 7, and the value 000 means a count of 8.
- R3: With `cnt_src`=1 the count is `cnt_reg`, taken as 0 to 63.
- R4: `op_code` 001 is an arithmetic right shift. Vacated bits take copies of the sign bit, and the last bit shifted out goes to both `c_out` and `x_out`, with `x_we`=1.
- R5: `op_code` 000 (arithmetic left), 010 (logical left) and 011 (logical right) fill vacated bits with 0. The last bit shifted out goes to both `c_out` and `x_out`, with `x_we`=1.
- R6: `op_code` 100 (rotate left) and 101 (rotate right) move each bit that leaves one end into the other end. `c_out` is the last bit moved, `x_we`=0 and `x_out` equals `x_in`.
- R7: `op_code` 110 (left) and 111 (right) rotate the operand together with `x_in` as an extra bit above the top bit. The bit that ends up in that extra position drives both `x_out` and `c_out`, with `x_we`=1.
- R8: `v_out` is 1 only for op 000, and only when the top bit of the sized value changes during any single step of the shift.
- R9: With an effective count of 0, the sized result equals the operand, `x_we`=0 and `x_out`=`x_in`. `c_out` is 0, except for ops 110 and 111, where `c_out` equals `x_in`.
- R10: `n_out` is the top bit of the sized result, and `z_out` is 1 exactly when every sized result bit is 0.
- R11: With `mem_mode`=1 the operation uses word size and a count of 1, whatever `size_sel`, `cnt_src`, `cnt_imm` and `cnt_reg` hold.
- R12: All outputs are registered and show the result for the inputs present at the previous rising clock edge. While `rst` is high, all outputs are 0.
- R13: When `x_we`=0, `x_out` equals `x_in`. When `x_we`=1, `x_out` equals `c_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Operation select (see R4 to R7) |
| size_sel | input | 2 | Operand size select |
| mem_mode | input | 1 | Forces a word shift by one |
| cnt_src | input | 1 | 0: instruction count field, 1: count register |
| cnt_imm | input | 3 | Count field, 000 means 8 |
| cnt_reg | input | 6 | Low six bits of the count register |
| dst_in | input | 32 | Destination register value |
| x_in | input | 1 | Current extend flag |
| res_out | output | 32 | New destination register value |
| x_out | output | 1 | New extend flag |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| v_out | output | 1 | Overflow flag |
| c_out | output | 1 | Carry flag |
| x_we | output | 1 | Extend flag write enable |

## Verification
The bound checker checks, on every cycle, these invariants:

- Bits above the selected size are preserved.
- Plain rotates never request an extend write.
- Overflow appears only after an arithmetic left shift.
- The extend output either follows carry or holds the incoming flag.
- A zero register count leaves the operand untouched.
- Zero and negative are never set together.

Only the bench's sweeps can show the exact bit values for every operation, size and count. These include the fill bit, the last bit shifted out, rotation through extend over counts larger than the width, the overflow rule across many steps, and the forced word-by-one memory form.

// File: rtl/shiftrot_pkg.sv
`timescale 1ns/1ps
package shiftrot_pkg;

    localparam int DATA_W    = 32;
    localparam int CNT_W     = 6;
    localparam int IMM_W     = 3;
    localparam int BASE_W    = 8;
    localparam int NUM_LANES = 3;

    typedef enum logic [2:0] {
        OP_ASL = 3'b000,
        OP_ASR = 3'b001,
        OP_LSL = 3'b010,
        OP_LSR = 3'b011,
        OP_ROL = 3'b100,
        OP_ROR = 3'b101,
        OP_RXL = 3'b110,
        OP_RXR = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_LONG  = 2'b10,
        SZ_LONG2 = 2'b11
    } size_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              x;
        logic              n;
        logic              z;
        logic              v;
        logic              c;
        logic              xwe;
    } shr_res_t;

    function automatic int lane_w(input int idx);
        return BASE_W << idx;
    endfunction

    function automatic int size_lane(input size_e sz);
        case (sz)
            SZ_BYTE: return 0;
            SZ_WORD: return 1;
            default: return 2;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input int idx);
        return {DATA_W{1'b1}} >> (DATA_W - lane_w(idx));
    endfunction

    function automatic logic is_rx(input op_e op);
        return (op == OP_RXL) || (op == OP_RXR);
    endfunction

    function automatic logic is_plain_rot(input op_e op);
        return (op == OP_ROL) || (op == OP_ROR);
    endfunction

endpackage

// File: rtl/shiftrot_count.sv
`timescale 1ns/1ps
module shiftrot_count
    import shiftrot_pkg::*;
(
    input  logic             mem_mode,
    input  logic             cnt_src,
    input  logic [IMM_W-1:0] cnt_imm,
    input  logic [CNT_W-1:0] cnt_reg,
    input  size_e            size_req,
    output logic [CNT_W-1:0] cnt_eff,
    output size_e            size_eff
);

    localparam logic [CNT_W-1:0] IMM_ZERO_CNT = CNT_W'(1 << IMM_W);

    always_comb begin
        if (mem_mode) begin
            cnt_eff  = CNT_W'(1);
            size_eff = SZ_WORD;
        end else begin
            size_eff = size_req;
            if (cnt_src)
                cnt_eff = cnt_reg;
            else if (cnt_imm == '0)
                cnt_eff = IMM_ZERO_CNT;
            else
                cnt_eff = CNT_W'(cnt_imm);
        end
    end

endmodule

// File: rtl/shiftrot_lane.sv
`timescale 1ns/1ps
module shiftrot_lane
    import shiftrot_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = CNT_W
) (
    input  logic [W-1:0]  v_in,
    input  op_e           op,
    input  logic [CW-1:0] cnt,
    input  logic          x_in,
    output logic [W-1:0]  v_out,
    output logic          c_out,
    output logic          v_flag
);

    localparam int MAX_STEPS = (1 << CW) - 1;

    always_comb begin
        logic [W-1:0] acc;
        logic         cy;
        logic         xr;
        logic         prev;
        acc    = v_in;
        xr     = x_in;
        cy     = is_rx(op) ? x_in : 1'b0;
        prev   = 1'b0;
        v_flag = 1'b0;
        for (int i = 0; i < MAX_STEPS; i++) begin
            if (i < int'(cnt)) begin
                prev = acc[W-1];
                case (op)
                    OP_ASL, OP_LSL: begin
                        cy  = acc[W-1];
                        acc = {acc[W-2:0], 1'b0};
                    end
                    OP_ASR: begin
                        cy  = acc[0];
                        acc = {acc[W-1], acc[W-1:1]};
                    end
                    OP_LSR: begin
                        cy  = acc[0];
                        acc = {1'b0, acc[W-1:1]};
                    end
                    OP_ROL: begin
                        cy  = acc[W-1];
                        acc = {acc[W-2:0], acc[W-1]};
                    end
                    OP_ROR: begin
                        cy  = acc[0];
                        acc = {acc[0], acc[W-1:1]};
                    end
                    OP_RXL: begin
                        cy  = acc[W-1];
                        acc = {acc[W-2:0], xr};
                        xr  = cy;
                    end
                    OP_RXR: begin
                        cy  = acc[0];
                        acc = {xr, acc[W-1:1]};
                        xr  = cy;
                    end
                endcase
                if (op == OP_ASL && acc[W-1] != prev)
                    v_flag = 1'b1;
            end
        end
        v_out = acc;
        c_out = cy;
    end

endmodule

// File: rtl/shiftrot_merge.sv
`timescale 1ns/1ps
module shiftrot_merge
    import shiftrot_pkg::*;
(
    input  op_e              op,
    input  size_e            size_eff,
    input  logic [CNT_W-1:0] cnt_eff,
    input  logic [DATA_W-1:0] dst_in,
    input  logic             x_in,
    input  logic [DATA_W-1:0] lane_res [NUM_LANES],
    input  logic             lane_c   [NUM_LANES],
    input  logic             lane_v   [NUM_LANES],
    output shr_res_t         nxt
);

    always_comb begin
        int                idx;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] sized;
        idx     = size_lane(size_eff);
        mask    = lane_mask(idx);
        sized   = lane_res[idx] & mask;
        nxt.res = (dst_in & ~mask) | sized;
        nxt.n   = sized[lane_w(idx)-1];
        nxt.z   = (sized == '0);
        nxt.v   = lane_v[idx];
        nxt.c   = lane_c[idx];
        nxt.xwe = (cnt_eff != '0) && !is_plain_rot(op);
        nxt.x   = nxt.xwe ? lane_c[idx] : x_in;
    end

endmodule

// File: rtl/shiftrot_unit.sv
`timescale 1ns/1ps
module shiftrot_unit
    import shiftrot_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  op_code,
    input  logic [1:0]  size_sel,
    input  logic        mem_mode,
    input  logic        cnt_src,
    input  logic [2:0]  cnt_imm,
    input  logic [5:0]  cnt_reg,
    input  logic [31:0] dst_in,
    input  logic        x_in,
    output logic [31:0] res_out,
    output logic        x_out,
    output logic        n_out,
    output logic        z_out,
    output logic        v_out,
    output logic        c_out,
    output logic        x_we
);

    op_e               op;
    size_e             size_eff;
    logic [CNT_W-1:0]  cnt_eff;
    logic [DATA_W-1:0] lane_res [NUM_LANES];
    logic              lane_c   [NUM_LANES];
    logic              lane_v   [NUM_LANES];
    shr_res_t          nxt;
    shr_res_t          out_q;

    assign op = op_e'(op_code);

    shiftrot_count u_count (
        .mem_mode (mem_mode),
        .cnt_src  (cnt_src),
        .cnt_imm  (cnt_imm),
        .cnt_reg  (cnt_reg),
        .size_req (size_e'(size_sel)),
        .cnt_eff  (cnt_eff),
        .size_eff (size_eff)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = lane_w(g);
        logic [LW-1:0] lo;
        shiftrot_lane #(.W(LW), .CW(CNT_W)) u_lane (
            .v_in   (dst_in[LW-1:0]),
            .op     (op),
            .cnt    (cnt_eff),
            .x_in   (x_in),
            .v_out  (lo),
            .c_out  (lane_c[g]),
            .v_flag (lane_v[g])
        );
        assign lane_res[g] = DATA_W'(lo);
    end

    shiftrot_merge u_merge (
        .op       (op),
        .size_eff (size_eff),
        .cnt_eff  (cnt_eff),
        .dst_in   (dst_in),
        .x_in     (x_in),
        .lane_res (lane_res),
        .lane_c   (lane_c),
        .lane_v   (lane_v),
        .nxt      (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else
            out_q <= nxt;
    end

    assign res_out = out_q.res;
    assign x_out   = out_q.x;
    assign n_out   = out_q.n;
    assign z_out   = out_q.z;
    assign v_out   = out_q.v;
    assign c_out   = out_q.c;
    assign x_we    = out_q.xwe;

endmodule

// File: rtl/shiftrot_chk.sv
`timescale 1ns/1ps
module shiftrot_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  op_code,
    input logic [1:0]  size_sel,
    input logic        mem_mode,
    input logic        cnt_src,
    input logic [5:0]  cnt_reg,
    input logic [31:0] dst_in,
    input logic        x_in,
    input logic [31:0] res_out,
    input logic        x_out,
    input logic        n_out,
    input logic        z_out,
    input logic        v_out,
    input logic        c_out,
    input logic        x_we
);

    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    a_r1_byte_upper_kept: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(!mem_mode && size_sel == 2'b00)
        |-> res_out[31:8] == $past(dst_in[31:8]));

    a_r11_word_upper_kept: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(mem_mode || size_sel == 2'b01)
        |-> res_out[31:16] == $past(dst_in[31:16]));

    a_r6_rotate_keeps_x: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(op_code == 3'b100 || op_code == 3'b101)
        |-> !x_we && x_out == $past(x_in));

    a_r8_v_only_asl: assert property (@(posedge clk) disable iff (rst)
        live_q && v_out |-> $past(op_code) == 3'b000);

    a_r13_x_source: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (x_we ? x_out == c_out : x_out == $past(x_in)));

    a_r9_zero_count: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(!mem_mode && cnt_src && cnt_reg == 6'd0)
        |-> res_out == $past(dst_in) && !x_we);

    a_r10_z_excludes_n: assert property (@(posedge clk) disable iff (rst)
        z_out |-> !n_out);

endmodule

bind shiftrot_unit shiftrot_chk chk_i (.*);

// File: tb/shiftrot_unit_tb_top.sv
`timescale 1ns/1ps
module shiftrot_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_code = '0;
    logic [1:0]  size_sel = '0;
    logic        mem_mode = 1'b0;
    logic        cnt_src = 1'b0;
    logic [2:0]  cnt_imm = '0;
    logic [5:0]  cnt_reg = '0;
    logic [31:0] dst_in = '0;
    logic        x_in = 1'b0;
    logic [31:0] res_out;
    logic        x_out, n_out, z_out, v_out, c_out, x_we;

    int checks = 0;
    int errs   = 0;

    always #2 clk = ~clk;

    shiftrot_unit dut_i (
        .clk(clk), .rst(rst), .op_code(op_code), .size_sel(size_sel),
        .mem_mode(mem_mode), .cnt_src(cnt_src), .cnt_imm(cnt_imm),
        .cnt_reg(cnt_reg), .dst_in(dst_in), .x_in(x_in),
        .res_out(res_out), .x_out(x_out), .n_out(n_out), .z_out(z_out),
        .v_out(v_out), .c_out(c_out), .x_we(x_we)
    );

    function automatic void model(input logic [2:0] op, input int w, input int n,
                                  input logic [31:0] d, input logic x,
                                  output logic [31:0] r, output logic xo,
                                  output logic no, output logic zo,
                                  output logic vo, output logic co,
                                  output logic we);
        logic [63:0] mask, vs, rs, se, t, t2, m1, top;
        logic sg;
        int k;
        mask = (64'd1 << w) - 64'd1;
        vs   = {32'd0, d} & mask;
        sg   = vs[w-1];
        co = 1'b0; vo = 1'b0; rs = '0;
        case (op)
            3'd0, 3'd2: begin
                rs = (vs << n) & mask;
                if (n != 0 && n <= w) co = vs[w-n];
            end
            3'd1: begin
                se = sg ? (vs | ~mask) : vs;
                rs = 64'($signed(se) >>> n) & mask;
                if (n != 0) co = (n <= w) ? vs[n-1] : sg;
            end
            3'd3: begin
                rs = vs >> n;
                if (n != 0 && n <= w) co = vs[n-1];
            end
            3'd4: begin
                k  = n % w;
                rs = ((vs << k) | (vs >> (w - k))) & mask;
                if (n != 0) co = rs[0];
            end
            3'd5: begin
                k  = n % w;
                rs = ((vs >> k) | (vs << (w - k))) & mask;
                if (n != 0) co = rs[w-1];
            end
            default: begin
                m1 = (64'd1 << (w + 1)) - 64'd1;
                t  = vs | ({63'd0, x} << w);
                k  = n % (w + 1);
                if (op == 3'd6) t2 = ((t << k) | (t >> (w + 1 - k))) & m1;
                else            t2 = ((t >> k) | (t << (w + 1 - k))) & m1;
                rs = t2 & mask;
                co = t2[w];
            end
        endcase
        if (op == 3'd0) begin
            if (n >= w) vo = (vs != 0);
            else begin
                top = vs >> (w - 1 - n);
                vo  = !(top == 0 || top == ((64'd1 << (n + 1)) - 64'd1));
            end
        end
        we = (n != 0) && op != 3'd4 && op != 3'd5;
        xo = we ? co : x;
        r  = (d & ~mask[31:0]) | rs[31:0];
        no = rs[w-1];
        zo = (rs == 0);
    endfunction

    task automatic run_vec(input logic [2:0] op, input logic [1:0] sz, input logic mem,
                           input logic src, input logic [2:0] imm, input logic [5:0] creg,
                           input logic [31:0] d, input logic x);
        int w, n;
        logic [31:0] er;
        logic ex, en, ez, ev, ec, ewe;
        string tg;
        @(negedge clk);
        op_code = op; size_sel = sz; mem_mode = mem; cnt_src = src;
        cnt_imm = imm; cnt_reg = creg; dst_in = d; x_in = x;
        @(posedge clk); #1;
        if (mem) begin w = 16; n = 1; end
        else begin
            w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
            n = src ? int'(creg) : (imm == 3'd0 ? 8 : int'(imm));
        end
        model(op, w, n, d, x, er, ex, en, ez, ev, ec, ewe);
        case (op)
            3'd1:       tg = "R4";
            3'd0:       tg = "R5 R8";
            3'd2, 3'd3: tg = "R5";
            3'd4, 3'd5: tg = "R6";
            default:    tg = "R7";
        endcase
        if (mem)       tg = {tg, " R11"};
        else if (src)  tg = {tg, " R3"};
        else           tg = {tg, " R2"};
        if (n == 0)    tg = {tg, " R9"};
        checks++;
        if ({res_out, x_out, n_out, z_out, v_out, c_out, x_we} !==
            {er, ex, en, ez, ev, ec, ewe}) begin
            errs++;
            $display("FAIL %s (R1 R10 R12 R13) op=%0d w=%0d n=%0d d=%h x=%b got res=%h xnzvc=%b%b%b%b%b we=%b exp res=%h xnzvc=%b%b%b%b%b we=%b",
                     tg, op, w, n, d, x, res_out, x_out, n_out, z_out, v_out, c_out, x_we,
                     er, ex, en, ez, ev, ec, ewe);
        end
    endtask

    task automatic check_lit(input logic ok, input string tg, input logic [31:0] got,
                             input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s got=%h exp=%h", tg, got, exp);
        end
    endtask

    localparam logic [31:0] PATS [4] = '{32'h8000_0081, 32'hECA2_DD2F,
                                         32'h0000_0000, 32'h7F5A_7FFE};

    initial begin
        repeat (1000000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        // R12: reset clears every output
        op_code = 3'd7; dst_in = 32'hFFFF_FFFF; x_in = 1'b1; cnt_imm = 3'd1;
        repeat (3) @(posedge clk);
        #1;
        check_lit({res_out, x_out, n_out, z_out, v_out, c_out, x_we} == '0,
                  "R12 reset outputs", res_out, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R4 known vector: byte ASR by 3 of 0xAC
        run_vec(3'd1, 2'b00, 1'b0, 1'b0, 3'd3, 6'd0, 32'h1234_56AC, 1'b0);
        check_lit(res_out == 32'h1234_56F5 && c_out && x_out && !v_out,
                  "R4 vector", res_out, 32'h1234_56F5);
        // R8 known vector: long ASL by 5
        run_vec(3'd0, 2'b10, 1'b0, 1'b0, 3'd5, 6'd0, 32'hECA2_DD2F, 1'b0);
        check_lit(res_out == 32'h945B_A5E0 && c_out && x_out && v_out,
                  "R8 vector", res_out, 32'h945B_A5E0);

        // R1 R2 R3 R9 R10: sweep of ops, sizes, both count sources, operands, X
        for (int op = 0; op < 8; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int p = 0; p < 4; p++)
                    for (int xv = 0; xv < 2; xv++) begin
                        for (int c = 0; c < 64; c++)
                            run_vec(3'(op), 2'(sz), 1'b0, 1'b1, 3'd0, 6'(c), PATS[p], 1'(xv));
                        for (int c = 0; c < 8; c++)
                            run_vec(3'(op), 2'(sz), 1'b0, 1'b0, 3'(c), 6'd0, PATS[p], 1'(xv));
                    end

        // R11: memory mode overrides size and count
        for (int op = 0; op < 8; op++)
            for (int p = 0; p < 4; p++)
                for (int xv = 0; xv < 2; xv++) begin
                    run_vec(3'(op), 2'b00, 1'b1, 1'b1, 3'd5, 6'd40, PATS[p], 1'(xv));
                    run_vec(3'(op), 2'b10, 1'b1, 1'b0, 3'd0, 6'd0, PATS[p], 1'(xv));
                end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule